// File: doc/BRIEF.md
# Programmable Watchdog Timer with Steering

This block detects a stalled host processor. Software programs an 8-bit control word that holds a steering bit, a five-bit multiplier and a two-bit resolution select. The timeout is the multiplier times the chosen resolution. The count advances on a 16 Hz single-cycle enable, called the base tick. The host proves that it is alive in either of two ways: it toggles the kick input, or it writes the control word again. Each of these starts a full timeout period over.

If the period runs out, the block sets a sticky flag, and the steering bit decides what happens next. With steering cleared, a level interrupt is raised. It stays high until a kick edge arrives or the control word is written with zero. With steering set, an active-low reset pulse of fixed length is driven, the control word is cleared, and a one-cycle strobe tells neighbouring logic to clear its own control bits. A read strobe from the host clears the flag. A zero multiplier keeps the timer idle.

Top module: `wdt_steer`

## Requirements
- R1: After a synchronous reset, `cfg_o` is 0x00, `flag_o` and `irq_o` are 0, `rst_n_o` is 1 and `ctl_clear_o` is 0. The timer is disabled.
- R2: A write stores `wr_data_i` and returns it on `cfg_o` from the next cycle. Bit 7 is the steering bit, bits 6..2 are the multiplier and bits 1..0 are the resolution select.
- R3: The timeout lasts multiplier × resolution base ticks, counted from the restart. Select 00 is 1 tick, 01 is 4 ticks, 10 is 16 ticks and 11 is 64 ticks. `flag_o` rises on the edge that samples the final tick and not before it.
- R4: While the stored multiplier is zero, no number of base ticks produces an expiry.
- R5: A write restarts a full timeout period, counted from the write.
- R6: A rising or a falling edge on `kick_i` restarts a full timeout period. The edge passes a two-flop synchronizer and takes effect within three clock edges.
- R7: An expiry with steering 0 sets `irq_o`. `irq_o` stays high through flag reads and through writes of non-zero values.
- R8: `irq_o` is cleared by a kick edge or by writing 0x00. Writing 0x00 also disables the timer.
- R9: An expiry with steering 1 drives `rst_n_o` low for exactly `PULSE_CYCLES` clock cycles and pulses `ctl_clear_o` for one cycle. It also clears `cfg_o` to 0x00, which disables the timer, and it leaves `irq_o` unchanged.
- R10: `rd_flag_i` clears `flag_o` on the next edge. An expiry in the same cycle takes priority, and the flag ends up set.
- R11: Each restart produces at most one expiry. The count stops after it fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_i | input | 1 | 16 Hz single-cycle base tick enable |
| kick_i | input | 1 | Asynchronous kick; either edge restarts the period |
| wr_en_i | input | 1 | Control-word write strobe |
| wr_data_i | input | 8 | Control-word write data |
| rd_flag_i | input | 1 | Flag read strobe; clears the flag |
| cfg_o | output | 8 | Stored control word |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Level interrupt (steering 0) |
| rst_n_o | output | 1 | Active-low reset pulse (steering 1) |
| ctl_clear_o | output | 1 | One-cycle strobe to clear neighbouring control bits |

## Verification
A wrong remaining count or a wrong prescaler phase shows up as `flag_o` rising one or more ticks early or late. The bench therefore samples the flag just before and just after the final tick of each resolution. If the counter fails to stop after an expiry, the flag comes back on the next expiry after a read. If the reload path is wrong, a restart by write or by kick does not push the expiry out by a full period. A bad pulse counter changes how long `rst_n_o` stays low, and that is visible as soon as the pulse ends, `PULSE_CYCLES` cycles after the expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CFG_W    = 8;
  localparam int MULT_W   = 5;
  localparam int RES_W    = 2;
  // each resolution step is a factor of 2**RES_STEP base ticks
  localparam int RES_STEP = 2;
  localparam int PRE_W    = RES_STEP * ((1 << RES_W) - 1);

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdt_cfg_t;

  // mask of prescaler bits that must all be one for a resolution tick
  function automatic logic [PRE_W-1:0] res_mask(input logic [RES_W-1:0] sel);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < RES_STEP * int'(sel)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_i,
  output logic edge_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], kick_i};
  end

  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [RES_W-1:0] sel_i,
  output logic             res_tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = res_mask(sel_i);

  always_ff @(posedge clk) begin
    if (rst || restart_i) pre_q <= '0;
    else if (tick_i)      pre_q <= pre_q + 1'b1;
  end

  assign res_tick_o = tick_i && ((pre_q & mask) == mask);
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart_i,
  input  logic [W-1:0] load_i,
  input  logic         step_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (restart_i)             cnt_q <= load_i;
    else if (step_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // a restart in the same cycle wins over the final step
  assign expire_o = step_i && !restart_i && (cnt_q == W'(1));
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
  import wdt_pkg::*;
#(
  parameter int PULSE_CYCLES = 10_000_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick16_i,
  input  logic             kick_i,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             rd_flag_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             rst_n_o,
  output logic             ctl_clear_o
);
  localparam int PW_W = $clog2(PULSE_CYCLES + 1);

  wdt_cfg_t          cfg_q, wr_cfg;
  logic              kick_evt, restart, res_tick, expire;
  logic              expire_irq, expire_rst, wr_zero;
  logic [MULT_W-1:0] load_val;
  logic [PW_W-1:0]   pcnt_q;
  logic              flag_q, irq_q, rstn_q, clr_q;

  assign wr_cfg   = wdt_cfg_t'(wr_data_i);
  assign wr_zero  = wr_en_i && (wr_data_i == '0);
  assign restart  = wr_en_i || kick_evt;
  assign load_val = wr_en_i ? wr_cfg.mult : cfg_q.mult;

  wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .kick_i(kick_i), .edge_o(kick_evt)
  );

  wdt_prescale u_pre (
    .clk(clk), .rst(rst), .restart_i(restart), .tick_i(tick16_i),
    .sel_i(cfg_q.res), .res_tick_o(res_tick)
  );

  wdt_down_cnt #(.W(MULT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart_i(restart), .load_i(load_val),
    .step_i(res_tick), .expire_o(expire)
  );

  assign expire_irq = expire && !cfg_q.steer;
  assign expire_rst = expire &&  cfg_q.steer;

  // control word: expiry never coincides with a write (restart wins)
  always_ff @(posedge clk) begin
    if (rst)             cfg_q <= '0;
    else if (wr_en_i)    cfg_q <= wr_cfg;
    else if (expire_rst) cfg_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst)            flag_q <= 1'b0;
    else if (expire)    flag_q <= 1'b1;
    else if (rd_flag_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                      irq_q <= 1'b0;
    else if (expire_irq)          irq_q <= 1'b1;
    else if (kick_evt || wr_zero) irq_q <= 1'b0;
  end

  // reset pulse stretcher
  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      rstn_q <= 1'b1;
    end else if (expire_rst) begin
      pcnt_q <= PW_W'(PULSE_CYCLES - 1);
      rstn_q <= 1'b0;
    end else if (pcnt_q != '0) begin
      pcnt_q <= pcnt_q - 1'b1;
    end else begin
      rstn_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clr_q <= 1'b0;
    else     clr_q <= expire_rst;
  end

  assign cfg_o       = cfg_q;
  assign flag_o      = flag_q;
  assign irq_o       = irq_q;
  assign rst_n_o     = rstn_q;
  assign ctl_clear_o = clr_q;
endmodule

// File: rtl/wdt_steer_chk.sv
module wdt_steer_chk #(
  parameter int PULSE_CYCLES = 10_000_000
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       rd_flag_i,
  input logic       kick_evt,
  input logic       expire,
  input logic [7:0] cfg_o,
  input logic       flag_o,
  input logic       irq_o,
  input logic       rst_n_o,
  input logic       ctl_clear_o
);
  int unsigned low_cnt;

  always_ff @(posedge clk) begin
    if (rst)           low_cnt <= 0;
    else if (!rst_n_o) low_cnt <= low_cnt + 1;
    else               low_cnt <= 0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (cfg_o == 8'h00 && !flag_o && !irq_o && rst_n_o && !ctl_clear_o));

  // R4
  zero_mult_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_o[6:2] == 5'd0 && !wr_en_i) |=> !$rose(flag_o));

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !kick_evt && !(wr_en_i && wr_data_i == 8'h00)) |=> irq_o);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_flag_i && !expire) |=> !flag_o);

  // R9
  pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_n_o |-> (low_cnt < PULSE_CYCLES));

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> (low_cnt == PULSE_CYCLES));

  // R9
  clear_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_clear_o |-> (!rst_n_o && cfg_o == 8'h00 && flag_o));
endmodule

bind wdt_steer wdt_steer_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_flag_i(rd_flag_i), .kick_evt(kick_evt), .expire(expire),
  .cfg_o(cfg_o), .flag_o(flag_o), .irq_o(irq_o), .rst_n_o(rst_n_o),
  .ctl_clear_o(ctl_clear_o)
);

// File: tb/wdt_steer_tb.sv
module wdt_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW         = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, kick = 1'b0, wr_en = 1'b0, rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] cfg;
  logic       flag, irq, rstn, clr;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    string      req;
    logic [7:0] cfg;
    logic       flag, irq, rstn, clr;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_steer #(.PULSE_CYCLES(PW)) u_dut (
    .clk(clk), .rst(rst), .tick16_i(tick), .kick_i(kick),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_flag_i(rd),
    .cfg_o(cfg), .flag_o(flag), .irq_o(irq), .rst_n_o(rstn),
    .ctl_clear_o(clr)
  );

  // monitor: compares each queued expectation against the ports
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      total++;
      if (cfg !== e.cfg || flag !== e.flag || irq !== e.irq ||
          rstn !== e.rstn || clr !== e.clr) begin
        fails++;
        $display("FAIL %s: got cfg=%h flag=%b irq=%b rstn=%b clr=%b, expected cfg=%h flag=%b irq=%b rstn=%b clr=%b",
                 e.req, cfg, flag, irq, rstn, clr, e.cfg, e.flag, e.irq, e.rstn, e.clr);
      end
    end
  end

  // driver helpers; all start and end on a falling edge
  task automatic expect_st(string req, logic [7:0] c, logic f, logic i,
                           logic rn, logic cl);
    exp_t e;
    e.req = req; e.cfg = c; e.flag = f; e.irq = i; e.rstn = rn; e.clr = cl;
    exp_q.push_back(e);
    #1;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic wr(logic [7:0] v);
    wr_en = 1'b1; wr_data = v; @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_flag();
    rd = 1'b1; @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic kick_toggle();
    kick = ~kick; cyc(4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    cyc(3); rst = 1'b0;
    expect_st("R1 reset state", 8'h00, 0, 0, 1, 0);

    ticks(100);
    expect_st("R4 zero multiplier idle", 8'h00, 0, 0, 1, 0);

    // mult 3, select 00 -> 3 ticks
    wr(8'h0C);
    expect_st("R2 readback", 8'h0C, 0, 0, 1, 0);
    ticks(2);
    expect_st("R3 sel00 before", 8'h0C, 0, 0, 1, 0);
    ticks(1);
    expect_st("R3 sel00 expiry / R7 irq", 8'h0C, 1, 1, 1, 0);

    rd_flag();
    expect_st("R10 read clears flag / R7 irq stays", 8'h0C, 0, 1, 1, 0);
    ticks(20);
    expect_st("R11 single expiry", 8'h0C, 0, 1, 1, 0);

    kick_toggle();
    expect_st("R8 kick clears irq", 8'h0C, 0, 0, 1, 0);
    ticks(2);
    expect_st("R6 kick restart before", 8'h0C, 0, 0, 1, 0);
    ticks(1);
    expect_st("R6 kick restart expiry", 8'h0C, 1, 1, 1, 0);

    // mult 3, select 01 -> 12 ticks; non-zero write keeps irq
    rd_flag();
    wr(8'h0D);
    expect_st("R7 nonzero write keeps irq", 8'h0D, 0, 1, 1, 0);
    ticks(11);
    expect_st("R3 sel01 before", 8'h0D, 0, 1, 1, 0);
    ticks(1);
    expect_st("R3 sel01 expiry", 8'h0D, 1, 1, 1, 0);

    wr(8'h00);
    expect_st("R8 zero write clears irq", 8'h00, 1, 0, 1, 0);
    rd_flag();
    ticks(70);
    expect_st("R8 zero write disables", 8'h00, 0, 0, 1, 0);

    // mult 3, select 10 -> 48 ticks
    wr(8'h0E);
    ticks(47);
    expect_st("R3 sel10 before", 8'h0E, 0, 0, 1, 0);
    ticks(1);
    expect_st("R3 sel10 expiry", 8'h0E, 1, 1, 1, 0);
    rd_flag();
    kick_toggle(); // falling edge
    expect_st("R8 falling kick clears irq", 8'h0E, 0, 0, 1, 0);

    // restart by rising and falling kick
    wr(8'h0C);
    ticks(2);
    kick_toggle(); // rising
    ticks(2);
    expect_st("R6 rising kick pushes expiry", 8'h0C, 0, 0, 1, 0);
    ticks(1);
    expect_st("R6 rising kick expiry", 8'h0C, 1, 1, 1, 0);
    rd_flag();
    kick_toggle(); // falling, clears irq and restarts
    ticks(2);
    kick_toggle(); // rising, restarts again
    ticks(2);
    expect_st("R6 falling kick pushes expiry", 8'h0C, 0, 0, 1, 0);
    ticks(1);
    expect_st("R6 kick expiry after", 8'h0C, 1, 1, 1, 0);

    // restart by write
    rd_flag();
    kick_toggle();
    ticks(2);
    wr(8'h0C);
    ticks(2);
    expect_st("R5 write pushes expiry", 8'h0C, 0, 0, 1, 0);
    ticks(1);
    expect_st("R5 write restart expiry", 8'h0C, 1, 1, 1, 0);

    // mult 1, select 11 -> 64 ticks
    rd_flag();
    kick_toggle();
    wr(8'h07);
    ticks(63);
    expect_st("R3 sel11 before", 8'h07, 0, 0, 1, 0);
    ticks(1);
    expect_st("R3 sel11 expiry", 8'h07, 1, 1, 1, 0);

    // expiry and read in the same cycle
    rd_flag();
    kick_toggle();
    wr(8'h04);
    tick = 1'b1; rd = 1'b1; @(negedge clk);
    tick = 1'b0; rd = 1'b0;
    expect_st("R10 expiry wins over read", 8'h04, 1, 1, 1, 0);
    rd_flag();
    expect_st("R10 later read clears", 8'h04, 0, 1, 1, 0);

    // steering 1: reset pulse
    kick_toggle();
    wr(8'h8C);
    ticks(2);
    expect_st("R9 before expiry", 8'h8C, 0, 0, 1, 0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    expect_st("R9 pulse start", 8'h00, 1, 0, 0, 1);
    for (int k = 1; k < PW; k++) begin
      @(negedge clk);
      expect_st("R9 pulse held", 8'h00, 1, 0, 0, 0);
    end
    @(negedge clk);
    expect_st("R9 pulse ends", 8'h00, 1, 0, 1, 0);
    ticks(100);
    expect_st("R9 timer disabled after", 8'h00, 1, 0, 1, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule